// File: doc/BRIEF.md
# Switch register access bridge

The bridge gives a host processor a small 32-bit register window through which it reaches a paged switch register space. The host first takes ownership of the switch bus through a request/grant handshake. That ownership is arbitrated against a second on-chip requester. The host then loads up to 64 bits of write data as a high and a low word. It writes a command word that names an 8-bit page, an 8-bit register offset and the transfer direction, with the go bit set.

The bridge issues the transfer once on a valid/ready switch-side bus and waits for the response strobe. It stores any returned read data in two read-back words and clears the go bit, which the host polls for completion. Narrow accesses (8/16/32 bits) use only the low words. A 48-bit access uses the low word plus the low half of the high word. Host software applies these masks; the bridge always moves the full 64 bits. A self-clearing reset bit in the command word aborts a transfer that is stuck.

Top module: `swreg_bridge`

## Requirements
- R1: After reset the grant outputs are low, no switch request is issued, and the command word (offset 0x2c) and both read-data words (0x38 high, 0x3c low) read 0. The control word (offset 0x40) reads back only bit 6, which mirrors `sw_init_done`.
- R2: Writing control bit 3 (request) to 1 while the other requester is idle makes control bit 4 (grant) read 1 on the second clock edge after the write. Bit 6 cannot be written. All control bits other than 3, 4 and 6 read 0.
- R3: The other requester has priority. While `alt_req` is high and the bus is not owned, the host is never granted. The host and the other requester never hold grant at the same time.
- R4: Clearing the request bit drops the host grant on the next edge when no transfer is in flight. A pending `alt_req` is then granted within two edges. `alt_req` is not granted while the host still holds the bus.
- R5: A command write at 0x2c with bit 0 set, made while the host holds grant and the bridge is idle, raises `sw_req_valid` on the next edge. The request carries page = bits [31:24], register = bits [23:16], write flag = bit 1, and write data = {word at 0x30, word at 0x34}. All of these are held stable until `sw_req_ready`.
- R6: Command bit 0 reads 1 from the accepted command until the edge on which `sw_rsp_valid` arrives, and reads 0 from then on. Bits [31:16] and bit 1 read back the accepted command. Bits [15:2] read 0.
- R7: For a read, the response data is stored as its upper 32 bits at 0x38 and its lower 32 bits at 0x3c. A write transfer leaves both read-data words unchanged.
- R8: A command written while the host lacks grant, or while a transfer is in flight, is ignored. No extra switch request is made, and the go bit stays clear or keeps tracking the transfer already running.
- R9: A command write with bit 2 set drops `sw_req_valid`, clears the go bit and zeroes both read-data words. A response that arrives later is ignored. Bit 2 always reads 0.
- R10: Host grant is not removed while a transfer is in flight, even if the request bit is cleared. It drops only after the transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr_en | input | 1 | Host register write strobe |
| hst_addr | input | 8 | Host register byte offset (read and write) |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for `hst_addr` (combinational) |
| sw_init_done | input | 1 | Switch initialisation complete flag |
| alt_req | input | 1 | Second requester asks for the switch bus |
| alt_gnt | output | 1 | Second requester owns the switch bus |
| sw_req_valid | output | 1 | Switch-side request valid |
| sw_req_ready | input | 1 | Switch accepts the request |
| sw_req_page | output | 8 | Request page |
| sw_req_reg | output | 8 | Request register offset |
| sw_req_write | output | 1 | 1 = write, 0 = read |
| sw_req_wdata | output | 64 | Request write data |
| sw_rsp_valid | input | 1 | Response strobe |
| sw_rsp_rdata | input | 64 | Response read data |

## Verification
Some properties are checked on every cycle. Grant exclusivity holds at all times. The switch request stays stable while it waits for ready. The switch is only addressed while the host owns it. A request begins only after a granted go command, and a reset command removes any pending request. The bench scenarios cover the behaviour that depends on stored data and ordering. This includes the read data landing in the right words, a write leaving them untouched, and commands being ignored during a transfer or without grant. It also covers a late response being discarded after an abort, and the exact edge on which grant and the go bit change.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int HOST_W = 32;
  localparam int PAGE_W = 8;
  localparam int REGA_W = 8;
  localparam int XDAT_W = 2 * HOST_W;

  localparam logic [7:0] OFS_CMD  = 8'h2c;
  localparam logic [7:0] OFS_WHI  = 8'h30;
  localparam logic [7:0] OFS_WLO  = 8'h34;
  localparam logic [7:0] OFS_RHI  = 8'h38;
  localparam logic [7:0] OFS_RLO  = 8'h3c;
  localparam logic [7:0] OFS_CTRL = 8'h40;

  localparam int CMD_GO_BIT   = 0;
  localparam int CMD_WR_BIT   = 1;
  localparam int CMD_KILL_BIT = 2;
  localparam int CMD_REG_LSB  = 16;
  localparam int CMD_PAGE_LSB = 24;

  localparam int CTL_REQ_BIT  = 3;
  localparam int CTL_GNT_BIT  = 4;
  localparam int CTL_INIT_BIT = 6;

  typedef enum logic [1:0] {OWN_NONE, OWN_HOST, OWN_ALT} owner_t;
  typedef enum logic [1:0] {XS_IDLE, XS_ISSUE, XS_WAIT} xact_st_t;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [REGA_W-1:0] rega;
    logic              wr;
  } cmd_t;
endpackage

// File: rtl/swb_arbiter.sv
module swb_arbiter
  import swb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic alt_req,
  input  logic host_busy,
  output logic host_gnt,
  output logic alt_gnt
);
  owner_t own_q, own_d;

  always_comb begin
    own_d = own_q;
    case (own_q)
      OWN_NONE: begin
        if (alt_req)       own_d = OWN_ALT;
        else if (host_req) own_d = OWN_HOST;
      end
      OWN_HOST: begin
        if (!host_req && !host_busy) own_d = alt_req ? OWN_ALT : OWN_NONE;
      end
      OWN_ALT: begin
        if (!alt_req) own_d = host_req ? OWN_HOST : OWN_NONE;
      end
      default: own_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_NONE;
    else        own_q <= own_d;
  end

  assign host_gnt = (own_q == OWN_HOST);
  assign alt_gnt  = (own_q == OWN_ALT);
endmodule

// File: rtl/swb_regfile.sv
module swb_regfile
  import swb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HOST_W-1:0] wdata,
  output logic [HOST_W-1:0] rdata,
  input  logic              init_done,
  input  logic              host_gnt,
  input  logic              busy,
  input  cmd_t              cur_cmd,
  input  logic              cap_en,
  input  logic [XDAT_W-1:0] cap_data,
  output logic              host_req,
  output logic              start,
  output logic              abort,
  output cmd_t              new_cmd,
  output logic [XDAT_W-1:0] wr_word
);
  localparam int PAD_W = CMD_REG_LSB - CMD_KILL_BIT;

  logic              req_q, req_d, req_en;
  logic [HOST_W-1:0] whi_q, wlo_q;
  logic [HOST_W-1:0] rhi_q, rlo_q, rhi_d, rlo_d;
  logic              whi_en, wlo_en, rd_en;
  logic              hit_cmd, hit_ctl, hit_whi, hit_wlo;

  assign hit_cmd = wr_en && (addr == ADDR_W'(OFS_CMD));
  assign hit_ctl = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign hit_whi = wr_en && (addr == ADDR_W'(OFS_WHI));
  assign hit_wlo = wr_en && (addr == ADDR_W'(OFS_WLO));

  assign abort = hit_cmd && wdata[CMD_KILL_BIT];
  assign start = hit_cmd && wdata[CMD_GO_BIT] && !wdata[CMD_KILL_BIT]
                 && host_gnt && !busy;

  assign new_cmd.page = wdata[CMD_PAGE_LSB +: PAGE_W];
  assign new_cmd.rega = wdata[CMD_REG_LSB +: REGA_W];
  assign new_cmd.wr   = wdata[CMD_WR_BIT];
  assign wr_word      = {whi_q, wlo_q};

  always_comb begin
    req_en = hit_ctl;
    req_d  = wdata[CTL_REQ_BIT];
    whi_en = hit_whi;
    wlo_en = hit_wlo;
    rd_en  = abort || cap_en;
    rhi_d  = abort ? '0 : cap_data[XDAT_W-1:HOST_W];
    rlo_d  = abort ? '0 : cap_data[HOST_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      whi_q <= '0;
      wlo_q <= '0;
      rhi_q <= '0;
      rlo_q <= '0;
    end else begin
      if (req_en) req_q <= req_d;
      if (whi_en) whi_q <= wdata;
      if (wlo_en) wlo_q <= wdata;
      if (rd_en) begin
        rhi_q <= rhi_d;
        rlo_q <= rlo_d;
      end
    end
  end

  assign host_req = req_q;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_CMD))
      rdata = {cur_cmd.page, cur_cmd.rega, {PAD_W{1'b0}}, cur_cmd.wr, busy};
    else if (addr == ADDR_W'(OFS_WHI)) rdata = whi_q;
    else if (addr == ADDR_W'(OFS_WLO)) rdata = wlo_q;
    else if (addr == ADDR_W'(OFS_RHI)) rdata = rhi_q;
    else if (addr == ADDR_W'(OFS_RLO)) rdata = rlo_q;
    else if (addr == ADDR_W'(OFS_CTRL)) begin
      rdata[CTL_REQ_BIT]  = req_q;
      rdata[CTL_GNT_BIT]  = host_gnt;
      rdata[CTL_INIT_BIT] = init_done;
    end
  end
endmodule

// File: rtl/swb_xact.sv
module swb_xact
  import swb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  cmd_t              new_cmd,
  input  logic [XDAT_W-1:0] wr_word,
  output cmd_t              cur_cmd,
  output logic              busy,
  output logic              cap_en,
  output logic [XDAT_W-1:0] cap_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [XDAT_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [XDAT_W-1:0] rsp_rdata
);
  xact_st_t st_q, st_d;
  cmd_t              cmd_q;
  logic [XDAT_W-1:0] wd_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      XS_IDLE:  if (start)     st_d = XS_ISSUE;
      XS_ISSUE: if (req_ready) st_d = XS_WAIT;
      XS_WAIT:  if (rsp_valid) st_d = XS_IDLE;
      default:                 st_d = XS_IDLE;
    endcase
    if (abort) st_d = XS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= XS_IDLE;
      cmd_q <= '0;
      wd_q  <= '0;
    end else begin
      st_q <= st_d;
      if (start) begin
        cmd_q <= new_cmd;
        wd_q  <= wr_word;
      end
    end
  end

  assign cur_cmd   = cmd_q;
  assign busy      = (st_q != XS_IDLE);
  assign req_valid = (st_q == XS_ISSUE);
  assign req_wdata = wd_q;
  assign cap_en    = (st_q == XS_WAIT) && rsp_valid && !cmd_q.wr && !abort;
  assign cap_data  = rsp_rdata;
endmodule

// File: rtl/swreg_bridge.sv
module swreg_bridge
  import swb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr_en,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [HOST_W-1:0] hst_wdata,
  output logic [HOST_W-1:0] hst_rdata,
  input  logic              sw_init_done,
  input  logic              alt_req,
  output logic              alt_gnt,
  output logic              sw_req_valid,
  input  logic              sw_req_ready,
  output logic [PAGE_W-1:0] sw_req_page,
  output logic [REGA_W-1:0] sw_req_reg,
  output logic              sw_req_write,
  output logic [XDAT_W-1:0] sw_req_wdata,
  input  logic              sw_rsp_valid,
  input  logic [XDAT_W-1:0] sw_rsp_rdata
);
  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  logic              host_req, host_gnt, busy, start, abort, cap_en;
  cmd_t              new_cmd, cur_cmd;
  logic [XDAT_W-1:0] wr_word, cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  swb_arbiter u_arb (
    .clk(clk), .rst_n(rst_s_n), .host_req(host_req), .alt_req(alt_req),
    .host_busy(busy), .host_gnt(host_gnt), .alt_gnt(alt_gnt)
  );

  swb_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(hst_wr_en), .addr(hst_addr),
    .wdata(hst_wdata), .rdata(hst_rdata), .init_done(sw_init_done),
    .host_gnt(host_gnt), .busy(busy), .cur_cmd(cur_cmd), .cap_en(cap_en),
    .cap_data(cap_data), .host_req(host_req), .start(start), .abort(abort),
    .new_cmd(new_cmd), .wr_word(wr_word)
  );

  swb_xact u_xact (
    .clk(clk), .rst_n(rst_s_n), .start(start), .abort(abort),
    .new_cmd(new_cmd), .wr_word(wr_word), .cur_cmd(cur_cmd), .busy(busy),
    .cap_en(cap_en), .cap_data(cap_data), .req_valid(sw_req_valid),
    .req_ready(sw_req_ready), .req_wdata(sw_req_wdata),
    .rsp_valid(sw_rsp_valid), .rsp_rdata(sw_rsp_rdata)
  );

  assign sw_req_page  = cur_cmd.page;
  assign sw_req_reg   = cur_cmd.rega;
  assign sw_req_write = cur_cmd.wr;
endmodule

// File: rtl/swreg_bridge_chk.sv
module swreg_bridge_chk
  import swb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_wr_en,
  input logic [ADDR_W-1:0] hst_addr,
  input logic [HOST_W-1:0] hst_wdata,
  input logic              alt_gnt,
  input logic              host_gnt,
  input logic              sw_req_valid,
  input logic              sw_req_ready,
  input logic [PAGE_W-1:0] sw_req_page,
  input logic [REGA_W-1:0] sw_req_reg,
  input logic              sw_req_write,
  input logic [XDAT_W-1:0] sw_req_wdata
);
  logic kill_wr, go_wr;
  assign kill_wr = hst_wr_en && (hst_addr == ADDR_W'(OFS_CMD)) && hst_wdata[CMD_KILL_BIT];
  assign go_wr   = hst_wr_en && (hst_addr == ADDR_W'(OFS_CMD)) && hst_wdata[CMD_GO_BIT];

  // R3
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(alt_gnt && host_gnt));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req_valid && !sw_req_ready && !kill_wr) |=>
      (sw_req_valid && $stable(sw_req_page) && $stable(sw_req_reg)
       && $stable(sw_req_write) && $stable(sw_req_wdata)));

  // R10
  owner_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req_valid |-> host_gnt);

  // R8
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_req_valid) |-> $past(go_wr && host_gnt));

  // R9
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_wr |=> !sw_req_valid);
endmodule

bind swreg_bridge swreg_bridge_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .hst_wr_en(hst_wr_en), .hst_addr(hst_addr),
  .hst_wdata(hst_wdata), .alt_gnt(alt_gnt), .host_gnt(host_gnt),
  .sw_req_valid(sw_req_valid), .sw_req_ready(sw_req_ready),
  .sw_req_page(sw_req_page), .sw_req_reg(sw_req_reg),
  .sw_req_write(sw_req_write), .sw_req_wdata(sw_req_wdata)
);

// File: tb/test_swreg_bridge.sv
`timescale 1ns/1ps
module test_swreg_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hst_wr_en;
  logic [7:0]  hst_addr;
  logic [31:0] hst_wdata;
  logic [31:0] hst_rdata;
  logic        sw_init_done, alt_req, alt_gnt;
  logic        sw_req_valid, sw_req_ready, sw_req_write, sw_rsp_valid;
  logic [7:0]  sw_req_page, sw_req_reg;
  logic [63:0] sw_req_wdata, sw_rsp_rdata;

  int n_vec = 0;
  int n_bad = 0;
  int ready_delay = 0;
  int rsp_delay = 0;
  int hs_count = 0;
  logic [63:0] mem [16];

  always #2 clk = ~clk;

  swreg_bridge i_swreg_bridge (
    .clk(clk), .rst_n(rst_n), .hst_wr_en(hst_wr_en), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .sw_init_done(sw_init_done),
    .alt_req(alt_req), .alt_gnt(alt_gnt), .sw_req_valid(sw_req_valid),
    .sw_req_ready(sw_req_ready), .sw_req_page(sw_req_page),
    .sw_req_reg(sw_req_reg), .sw_req_write(sw_req_write),
    .sw_req_wdata(sw_req_wdata), .sw_rsp_valid(sw_rsp_valid),
    .sw_rsp_rdata(sw_rsp_rdata)
  );

  function automatic logic [63:0] pat(int i);
    return {32'hC0DE0000 | 32'(i), 32'h0BAD0000 | 32'(i * 3)};
  endfunction

  always @(posedge clk) if (sw_req_valid && sw_req_ready) hs_count <= hs_count + 1;

  // switch register model
  initial begin
    int ph, cnt;
    logic [7:0]  l_reg;
    logic        l_wr;
    logic [63:0] l_wd;
    for (int i = 0; i < 16; i++) mem[i] = pat(i);
    sw_req_ready = 1'b0; sw_rsp_valid = 1'b0; sw_rsp_rdata = '0;
    ph = 0; cnt = 0; l_reg = '0; l_wr = 1'b0; l_wd = '0;
    forever begin
      @(negedge clk);
      if (ph == 0) begin
        sw_rsp_valid = 1'b0;
        if (sw_req_valid) begin
          if (cnt >= ready_delay) begin
            sw_req_ready = 1'b1;
            l_reg = sw_req_reg; l_wr = sw_req_write; l_wd = sw_req_wdata;
            ph = 1; cnt = 0;
          end else cnt++;
        end else cnt = 0;
      end else begin
        sw_req_ready = 1'b0;
        if (cnt >= rsp_delay) begin
          if (l_wr) begin mem[l_reg[3:0]] = l_wd; sw_rsp_rdata = 64'hDEAD_DEAD_DEAD_DEAD; end
          else sw_rsp_rdata = mem[l_reg[3:0]];
          sw_rsp_valid = 1'b1;
          ph = 0; cnt = 0;
        end else cnt++;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_wr_en = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr_en = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_addr = a;
    #0.5 d = hst_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int k = 0; k < 60; k++) begin
      hread(8'h2c, v);
      if (!v[0]) break;
    end
  endtask

  task automatic take_grant();
    logic [31:0] v;
    hwrite(8'h40, 32'h8);
    hread(8'h40, v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    hread(8'h40, v); check("R1 ctrl", v, 32'h0);
    hread(8'h2c, v); check("R1 cmd", v, 32'h0);
    hread(8'h38, v); check("R1 rd_hi", v, 32'h0);
    hread(8'h3c, v); check("R1 rd_lo", v, 32'h0);
    check("R1 gnt/valid", {alt_gnt, sw_req_valid}, 2'b00);
  endtask

  task automatic t_grant();
    logic [31:0] v;
    hwrite(8'h40, 32'hFFFF_FFA8);
    hread(8'h40, v); check("R2 grant, bit6 read-only", v, 32'h18);
    sw_init_done = 1'b1;
    hread(8'h40, v); check("R2 init mirror", v, 32'h58);
  endtask

  task automatic t_write_read();
    logic [31:0] v;
    ready_delay = 2; rsp_delay = 1;
    hwrite(8'h30, 32'h1122_3344);
    hwrite(8'h34, 32'h5566_7788);
    hwrite(8'h2c, 32'h1205_0003);
    #0.5;
    check("R5 valid", sw_req_valid, 1'b1);
    check("R5 fields", {sw_req_page, sw_req_reg, 7'b0, sw_req_write}, {8'h12, 8'h05, 8'h01});
    check("R5 wdata", sw_req_wdata, 64'h1122_3344_5566_7788);
    hread(8'h2c, v); check("R6 busy", v, 32'h1205_0003);
    wait_done();
    hread(8'h2c, v); check("R6 done", v, 32'h1205_0002);
    check("R5 stored", mem[5], 64'h1122_3344_5566_7788);
    ready_delay = 0; rsp_delay = 0;
    hwrite(8'h2c, 32'h1209_0001);
    wait_done();
    hread(8'h38, v); check("R7 rd_hi", v, pat(9) >> 32);
    hread(8'h3c, v); check("R7 rd_lo", v, pat(9) & 64'hFFFF_FFFF);
    hwrite(8'h2c, 32'h120A_0003);
    wait_done();
    hread(8'h38, v); check("R7 write keeps rd_hi", v, pat(9) >> 32);
    hread(8'h3c, v); check("R7 write keeps rd_lo", v, pat(9) & 64'hFFFF_FFFF);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int h0;
    h0 = hs_count; rsp_delay = 5;
    hwrite(8'h34, 32'hAAAA_0000);
    hwrite(8'h2c, 32'h0007_0001);
    hwrite(8'h2c, 32'h0008_0003);
    wait_done();
    idle(4);
    check("R8 one request while busy", 32'(hs_count - h0), 32'd1);
    check("R8 reg8 untouched", mem[8], pat(8));
    hread(8'h3c, v); check("R8 first read result", v, pat(7) & 64'hFFFF_FFFF);
    hread(8'h2c, v); check("R8 cmd unchanged", v, 32'h0007_0000);
    rsp_delay = 0;
  endtask

  task automatic t_no_grant();
    logic [31:0] v;
    int h0;
    hwrite(8'h40, 32'h0);
    hread(8'h40, v); check("R4 release", v, 32'h40);
    h0 = hs_count;
    hwrite(8'h2c, 32'h0003_0001);
    idle(4);
    hread(8'h2c, v); check("R8 go clear without grant", v[0], 1'b0);
    check("R8 no request without grant", 32'(hs_count - h0), 32'd0);
  endtask

  task automatic t_alt();
    logic [31:0] v;
    alt_req = 1'b1;
    idle(2);
    hwrite(8'h40, 32'h8);
    idle(3);
    hread(8'h40, v); check("R3 host blocked", v[4], 1'b0);
    check("R3 alt owns", alt_gnt, 1'b1);
    alt_req = 1'b0;
    idle(2);
    hread(8'h40, v); check("R3 host after alt", v[4], 1'b1);
    alt_req = 1'b1;
    idle(3);
    check("R4 alt waits for host", alt_gnt, 1'b0);
    hwrite(8'h40, 32'h0);
    idle(1);
    check("R4 alt granted after release", alt_gnt, 1'b1);
    alt_req = 1'b0;
    idle(2);
  endtask

  task automatic t_no_preempt();
    logic [31:0] v;
    take_grant();
    rsp_delay = 6;
    hwrite(8'h2c, 32'h0002_0001);
    hwrite(8'h40, 32'h0);
    idle(2);
    hread(8'h40, v); check("R10 grant held in flight", v[4], 1'b1);
    hread(8'h2c, v); check("R10 still busy", v[0], 1'b1);
    wait_done();
    idle(1);
    hread(8'h40, v); check("R10 grant drops after done", v[4], 1'b0);
    rsp_delay = 0;
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int h0;
    take_grant();
    ready_delay = 1000;
    hwrite(8'h2c, 32'h0004_0001);
    #0.5 check("R9 pending", sw_req_valid, 1'b1);
    hwrite(8'h2c, 32'h0000_0004);
    #0.5 check("R9 valid dropped", sw_req_valid, 1'b0);
    hread(8'h2c, v); check("R9 go/kill clear", v[2:0], 3'b000);
    hread(8'h3c, v); check("R9 rd_lo zeroed", v, 32'h0);
    hread(8'h38, v); check("R9 rd_hi zeroed", v, 32'h0);
    ready_delay = 0; rsp_delay = 8;
    h0 = hs_count;
    hwrite(8'h2c, 32'h0004_0001);
    for (int k = 0; k < 20 && hs_count == h0; k++) idle(1);
    hwrite(8'h2c, 32'h0000_0004);
    idle(15);
    hread(8'h3c, v); check("R9 late response ignored", v, 32'h0);
    hread(8'h2c, v); check("R9 go clear after abort", v[0], 1'b0);
    rsp_delay = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hst_wr_en = 1'b0; hst_addr = '0; hst_wdata = '0;
    sw_init_done = 1'b0; alt_req = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_grant();
    t_write_read();
    t_busy_ignore();
    t_no_grant();
    t_alt();
    t_no_preempt();
    t_abort();
    idle(4);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule